// File: doc/BRIEF.md
# Off-Hook DC Termination Mode Sequencer

This block lives on the controller side of a telephone line interface. When the host asks to go off-hook, the block chooses the line's DC termination mode and a 2-bit voltage-select setting. The choice follows a region profile fixed at the moment of off-hook. Two profiles start in a provisional mode, wait a settling delay counted in millisecond ticks, and then take one loop-current reading. That reading decides whether the block moves to the low-distortion (FCC-style) mode. The third profile takes no reading. It seizes the line in the low-voltage mode and moves to the FCC-style mode once a fixed hold time has passed.

After the decision, the block holds the chosen setting and raises a done flag. It keeps both until the host goes on-hook. Going on-hook at any point returns the block to idle with the reset outputs. The analog termination, the current measurement and any register access are outside the block. The loop current arrives as a sampled 4-bit value with a valid strobe.

Top module: `offhook_term_seq`

## Requirements
- R1: After reset, and while idle, `term_mode` is 0, `vsel` is 00 and `done` is 0. The `term_mode` codes are 0 = FCC-style, 1 = standard-region and 2 = low-voltage; code 3 is never driven.
- R2: Suppose a clock edge in idle sees `hook_req` high. One cycle later the outputs carry the profile's starting setting, with `done` at 0. The `profile` codes and their starting settings are: 0 = standard, giving mode 1 and vsel 00; 1 = low-voltage, giving mode 2 and vsel 01; 2 = seizure/hold, giving mode 2 and vsel 00; 3 behaves as 0.
- R3: In profiles 0, 1 and 3, the loop current is taken from the first `cur_vld` strobe seen once SETTLE_MS ticks of `ms_tick` have been counted since off-hook. Strobes seen earlier are ignored, including a strobe in the same cycle as the tick that completes the delay.
- R4: In the standard profile, a reading below 3 gives mode 0 and vsel 00. Any other reading keeps mode 1 with vsel 00.
- R5: In the low-voltage profile, a reading of 2 or less keeps mode 2 with vsel 01. A reading of 3 or more gives mode 0 with vsel 00. A nonzero `vsel` is only ever driven together with mode 2.
- R6: In the seizure/hold profile, the output moves to mode 0 with vsel 00 one cycle after the HOLD_MS-th tick counted since off-hook. Loop-current strobes have no effect in this profile.
- R7: `done` rises one cycle after the deciding strobe or tick. From then on, `done`, `term_mode` and `vsel` hold against further strobes, ticks and profile changes until on-hook.
- R8: A clock edge that sees `hook_req` low gives the R1 outputs one cycle later. This also happens when a deciding strobe or tick falls at the same edge.
- R9: The profile is captured at off-hook. Changing `profile` during the sequence does not alter the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hook_req | input | 1 | 1 = off-hook requested, 0 = on-hook |
| profile | input | 2 | Region profile code |
| cur_val | input | CUR_W | Sampled loop-current reading |
| cur_vld | input | 1 | One-cycle strobe marking `cur_val` valid |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| term_mode | output | 2 | DC termination mode code |
| vsel | output | 2 | Voltage-select field |
| done | output | 1 | Final setting reached and held |

## Verification
Two pairs of events can fall into one cycle. The first pair is the on-hook request and the decision itself: a deciding strobe or a final hold tick arriving at the same edge that sees `hook_req` fall. The second pair is a loop-current strobe and the tick that completes the settling delay.

The bench sweeps every profile against every 4-bit reading. In each run it provokes both collisions. Where the on-hook request and the decision coincide, the check expects idle outputs, not the decided mode. Where the strobe coincides with the completing tick, the check expects the provisional mode with `done` still low. The expected modes are computed from the threshold rules in the bench.

// File: rtl/ohs_pkg.sv
// Package: shared encodings for the off-hook termination sequencer.
// Assumes two-bit mode and profile codes, as listed in the brief.
package ohs_pkg;

    typedef enum logic [1:0] {
        TM_FCC  = 2'd0,
        TM_STD  = 2'd1,
        TM_LOWV = 2'd2
    } term_mode_e;

    typedef enum logic [1:0] {
        PR_STD   = 2'd0,
        PR_LOWV  = 2'd1,
        PR_SEIZE = 2'd2,
        PR_ALT   = 2'd3
    } profile_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_TIMED   = 2'd2,
        ST_LOCKED  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] vsel;
    } term_cfg_t;

    localparam term_cfg_t CFG_DEFAULT = '{mode: TM_FCC, vsel: 2'b00};

endpackage

// File: rtl/ohs_tick_count.sv
// Module: saturating millisecond-tick counter.
// Counts ms_tick pulses from zero after a clear and stops at LIMIT.
// Assumes the clear is held for as long as the sequencer is idle.
module ohs_tick_count #(
    parameter int LIMIT = 500,
    localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    // Purpose: clear on request, otherwise advance on each tick up to LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick && (count != LIM_C)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ohs_decide.sv
// Module: combinational termination choice.
// Gives the starting setting for a profile and the final setting for a
// captured profile and a loop-current reading. Assumes the readings are
// unsigned and that code 3 aliases the standard profile.
module ohs_decide
    import ohs_pkg::*;
#(
    parameter int CUR_W     = 4,
    parameter int STD_LIMIT = 3,
    parameter int LV_LIMIT  = 3
) (
    input  logic [1:0]       init_prof,
    input  logic [1:0]       final_prof,
    input  logic [CUR_W-1:0] cur,
    output term_cfg_t        init_cfg,
    output term_cfg_t        final_cfg
);
    localparam logic [CUR_W-1:0] STD_C = CUR_W'(STD_LIMIT);
    localparam logic [CUR_W-1:0] LV_C  = CUR_W'(LV_LIMIT);

    // Purpose: starting setting applied at the off-hook edge.
    always_comb begin
        case (profile_e'(init_prof))
            PR_LOWV:  init_cfg = '{mode: TM_LOWV, vsel: 2'b01};
            PR_SEIZE: init_cfg = '{mode: TM_LOWV, vsel: 2'b00};
            default:  init_cfg = '{mode: TM_STD,  vsel: 2'b00};
        endcase
    end

    // Purpose: final setting from the captured profile and the reading.
    always_comb begin
        case (profile_e'(final_prof))
            PR_LOWV: begin
                if (cur >= LV_C) final_cfg = '{mode: TM_FCC,  vsel: 2'b00};
                else             final_cfg = '{mode: TM_LOWV, vsel: 2'b01};
            end
            PR_SEIZE: final_cfg = '{mode: TM_FCC, vsel: 2'b00};
            default: begin
                if (cur < STD_C) final_cfg = '{mode: TM_FCC, vsel: 2'b00};
                else             final_cfg = '{mode: TM_STD, vsel: 2'b00};
            end
        endcase
    end
endmodule

// File: rtl/ohs_out_reg.sv
// Module: output register for the termination setting and done flag.
// A clear has priority over a load; a load writes the setting and done.
module ohs_out_reg
    import ohs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      load,
    input  term_cfg_t cfg_d,
    input  logic      done_d,
    output term_cfg_t cfg_q,
    output logic      done_q
);
    // Purpose: hold the driven setting; defaults on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cfg_q  <= CFG_DEFAULT;
            done_q <= 1'b0;
        end else if (load) begin
            cfg_q  <= cfg_d;
            done_q <= done_d;
        end
    end
endmodule

// File: rtl/offhook_term_seq.sv
// Module: top of the off-hook DC termination sequencer.
// Runs one decision per off-hook event: a measured choice after a settling
// delay, or a timed switch after HOLD_MS ticks. Assumes ms_tick and
// cur_vld are single-cycle pulses synchronous to clk. HOLD_MS is at least 1.
module offhook_term_seq
    import ohs_pkg::*;
#(
    parameter int CUR_W     = 4,
    parameter int SETTLE_MS = 8,
    parameter int HOLD_MS   = 500,
    parameter int STD_LIMIT = 3,
    parameter int LV_LIMIT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hook_req,
    input  logic [1:0]       profile,
    input  logic [CUR_W-1:0] cur_val,
    input  logic             cur_vld,
    input  logic             ms_tick,
    output logic [1:0]       term_mode,
    output logic [1:0]       vsel,
    output logic             done
);
    localparam int CNT_LIM = (SETTLE_MS > HOLD_MS) ? SETTLE_MS : HOLD_MS;
    localparam int CNT_W   = (CNT_LIM < 1) ? 1 : $clog2(CNT_LIM + 1);
    localparam logic [CNT_W-1:0] SETTLE_C   = CNT_W'(SETTLE_MS);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_MS - 1);

    seq_state_e       st_q, st_d;
    logic [1:0]       prof_q;
    logic [CNT_W-1:0] cnt;
    logic             settled, hold_hit;
    term_cfg_t        init_cfg, final_cfg, load_cfg, cfg_q;
    logic             load_en, clr_en, done_d;

    ohs_tick_count #(.LIMIT(CNT_LIM)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_q == ST_IDLE),
        .tick  (ms_tick),
        .count (cnt)
    );

    ohs_decide #(
        .CUR_W     (CUR_W),
        .STD_LIMIT (STD_LIMIT),
        .LV_LIMIT  (LV_LIMIT)
    ) u_dec (
        .init_prof  (profile),
        .final_prof (prof_q),
        .cur        (cur_val),
        .init_cfg   (init_cfg),
        .final_cfg  (final_cfg)
    );

    ohs_out_reg u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr_en),
        .load   (load_en),
        .cfg_d  (load_cfg),
        .done_d (done_d),
        .cfg_q  (cfg_q),
        .done_q (done)
    );

    assign settled  = (cnt >= SETTLE_C);
    assign hold_hit = (cnt == HOLD_LAST);

    // Purpose: next-state and output-load decisions of the sequence.
    always_comb begin
        st_d     = st_q;
        load_en  = 1'b0;
        done_d   = 1'b0;
        load_cfg = init_cfg;
        clr_en   = !hook_req;
        if (!hook_req) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_d    = (profile_e'(profile) == PR_SEIZE) ? ST_TIMED : ST_MEASURE;
                    load_en = 1'b1;
                end
                ST_MEASURE: begin
                    if (settled && cur_vld) begin
                        st_d     = ST_LOCKED;
                        load_en  = 1'b1;
                        load_cfg = final_cfg;
                        done_d   = 1'b1;
                    end
                end
                ST_TIMED: begin
                    if (ms_tick && hold_hit) begin
                        st_d     = ST_LOCKED;
                        load_en  = 1'b1;
                        load_cfg = final_cfg;
                        done_d   = 1'b1;
                    end
                end
                default: st_d = ST_LOCKED;
            endcase
        end
    end

    // Purpose: sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: capture the profile once, at the off-hook edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         prof_q <= 2'd0;
        else if (st_q == ST_IDLE && hook_req) prof_q <= profile;
    end

    assign term_mode = cfg_q.mode;
    assign vsel      = cfg_q.vsel;
endmodule

// File: rtl/ohs_checker.sv
// Module: temporal checks on the sequencer ports, bound to the top.
module ohs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hook_req,
    input logic       cur_vld,
    input logic       ms_tick,
    input logic [1:0] term_mode,
    input logic [1:0] vsel,
    input logic       done
);
    // R1: code 3 is never driven.
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        term_mode != 2'd3);

    // R2: an off-hook edge gives a provisional, non-final setting.
    p_init_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hook_req) |=> (term_mode != 2'd0) && !done);

    // R5: a nonzero voltage select appears only with the low-voltage mode.
    p_vsel_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsel != 2'b00) |-> (term_mode == 2'd2));

    // R7: once done, the setting holds while off-hook.
    p_hold_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hook_req) |=> done && $stable(term_mode) && $stable(vsel));

    // R7: done rises only after a strobe or a tick.
    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cur_vld) || $past(ms_tick)));

    // R8: on-hook restores the idle outputs one cycle later.
    p_onhook_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hook_req |=> (term_mode == 2'd0) && (vsel == 2'b00) && !done);
endmodule

bind offhook_term_seq ohs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hook_req  (hook_req),
    .cur_vld   (cur_vld),
    .ms_tick   (ms_tick),
    .term_mode (term_mode),
    .vsel      (vsel),
    .done      (done)
);

// File: tb/offhook_term_seq_tb.sv
// Bench: sweeps every profile against every reading, with collisions.
module offhook_term_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;
    localparam int HOLD       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hook_req = 1'b0;
    logic [1:0] profile = 2'd0;
    logic [3:0] cur_val = 4'd0;
    logic       cur_vld = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] term_mode, vsel;
    logic       done;

    int runs  = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    offhook_term_seq #(.CUR_W(4), .SETTLE_MS(SETTLE), .HOLD_MS(HOLD)) dut_i (
        .clk (clk), .rst_n (rst_n), .hook_req (hook_req), .profile (profile),
        .cur_val (cur_val), .cur_vld (cur_vld), .ms_tick (ms_tick),
        .term_mode (term_mode), .vsel (vsel), .done (done)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] em, input logic [1:0] ev,
                       input logic ed);
        runs++;
        if (term_mode !== em || vsel !== ev || done !== ed) begin
            fails++;
            $display("FAIL %s: actual mode=%0d vsel=%0d done=%0d expected mode=%0d vsel=%0d done=%0d",
                     req, term_mode, vsel, done, em, ev, ed);
        end
    endtask

    function automatic logic [4:0] exp_final(input int p, input int c);
        if (p == 1) return (c <= 2) ? {2'd2, 2'b01, 1'b1} : {2'd0, 2'b00, 1'b1};
        return (c < 3) ? {2'd0, 2'b00, 1'b1} : {2'd1, 2'b00, 1'b1};
    endfunction

    // Measured profiles: R2, R3, R4/R5, R7, R8, R9.
    task automatic run_meas(input int p, input int c, input bit collide);
        logic [1:0] im = (p == 1) ? 2'd2 : 2'd1;
        logic [1:0] iv = (p == 1) ? 2'b01 : 2'b00;
        logic [3:0] other = (c < 3) ? 4'd15 : 4'd0;
        logic [4:0] ex = exp_final(p, c);
        hook_req = 1'b1; profile = 2'(p);
        cyc(); chk("R2", im, iv, 1'b0);
        profile = (p == 1) ? 2'd0 : 2'd1;          // R9 change after capture
        cur_val = other; cur_vld = 1'b1;
        cyc(); cur_vld = 1'b0; chk("R3", im, iv, 1'b0);
        for (int i = 0; i < SETTLE - 1; i++) begin
            ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
        end
        ms_tick = 1'b1; cur_vld = 1'b1;            // strobe with completing tick
        cyc(); ms_tick = 1'b0; cur_vld = 1'b0; chk("R3", im, iv, 1'b0);
        cyc();
        cur_val = 4'(c); cur_vld = 1'b1;
        if (collide) hook_req = 1'b0;
        cyc(); cur_vld = 1'b0;
        if (collide) begin
            chk("R8", 2'd0, 2'b00, 1'b0);
            return;
        end
        chk((p == 1) ? "R5" : "R4", ex[4:3], ex[2:1], ex[0]);
        cur_val = other; cur_vld = 1'b1; ms_tick = 1'b1; profile = 2'd2;
        cyc(); cyc(); cur_vld = 1'b0; ms_tick = 1'b0;
        chk("R7", ex[4:3], ex[2:1], 1'b1);
        hook_req = 1'b0;
        cyc(); chk("R8", 2'd0, 2'b00, 1'b0);
    endtask

    // Seizure/hold profile: R2, R6, R7, R8.
    task automatic run_timed(input bit collide);
        hook_req = 1'b1; profile = 2'd2;
        cyc(); chk("R2", 2'd2, 2'b00, 1'b0);
        profile = 2'd0; cur_val = 4'd0; cur_vld = 1'b1;
        cyc(); cur_vld = 1'b0; chk("R6", 2'd2, 2'b00, 1'b0);
        for (int i = 0; i < HOLD - 1; i++) begin
            ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
            chk("R6", 2'd2, 2'b00, 1'b0);
        end
        ms_tick = 1'b1;
        if (collide) hook_req = 1'b0;
        cyc(); ms_tick = 1'b0;
        if (collide) begin
            chk("R8", 2'd0, 2'b00, 1'b0);
            return;
        end
        chk("R6", 2'd0, 2'b00, 1'b1);
        cur_vld = 1'b1; ms_tick = 1'b1; profile = 2'd1;
        cyc(); cyc(); cur_vld = 1'b0; ms_tick = 1'b0;
        chk("R7", 2'd0, 2'b00, 1'b1);
        hook_req = 1'b0;
        cyc(); chk("R8", 2'd0, 2'b00, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7: watchdog expired, actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        chk("R1", 2'd0, 2'b00, 1'b0);
        rst_n = 1'b1;
        cyc(); chk("R1", 2'd0, 2'b00, 1'b0);
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 2; k++) begin
                    run_meas(p, c, k[0]);
                    cyc(); chk("R1", 2'd0, 2'b00, 1'b0);
                end
            end
        end
        run_timed(1'b0);
        run_timed(1'b1);
        cyc(); chk("R1", 2'd0, 2'b00, 1'b0);
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule